// File: doc/BRIEF.md
# Parallel NOR Flash Query and Geometry Reader

This block interrogates a 16-bit parallel NOR flash through a small synchronous bus master port. The device is accessed one byte at a time, so every command offset appears on the bus doubled. A single-cycle start pulse launches a probe with these steps:

1. Return the device to its array state.
2. Switch it into query mode.
3. Confirm the three-letter query signature.

When the signature matches, the block gathers the device description from the query table. This covers the command-set code, the device-size exponent, the write and erase timeout exponents and the erase-block region table. Region descriptors are decoded as they arrive, into block counts, block sizes in bytes and cumulative start offsets.

After the reads, the block issues the exit writes that suit the command set. It then pulses done along with exactly one of two result flags, found or missing. The decoded fields stay on the outputs until the next accepted start. Boot or configuration logic can then use them to plan erase and program operations.

Top module: `cfi_probe`

## Requirements
- R1: Each bus address is twice the command offset it targets, so bit 0 of every address driven with a strobe is 0.
- R2: A probe starts with two writes, in this order: 0xF0 at offset 0x00, then 0x98 at offset 0x55.
- R3: The bytes at offsets 0x10, 0x11 and 0x12 must be 'Q', 'R' and 'Y'. On the first mismatch the block stops reading, issues no exit writes and ends with missing set.
- R4: The command-set code on `cmdset_o` is 16 bits: the low byte comes from offset 0x13 and the high byte from offset 0x14.
- R5: The write timeout exponent (9 bits) is byte[0x1F]+byte[0x23]. The erase timeout exponent (9 bits) is byte[0x21]+byte[0x25]. The size exponent is byte[0x27].
- R6: The region count is byte[0x2C], limited to MAX_REG (8). Only that many descriptors are read, four bytes each, starting at offset 0x2D.
- R7: The block count of region r is the little-endian 16-bit value at 0x2D+4r, plus one, held in 17 bits.
- R8: The block size of region r is 256 times the little-endian 16-bit value at 0x2D+4r+2. A value of zero gives 128 bytes.
- R9: The start offset of region 0 is 0. Each later region starts at the sum of size times count over all earlier regions, wrapping at OFS_W bits.
- R10: After a successful probe, the exit writes go to offset 0x00 and depend on the command set. Set 2 gets 0xF0 then 0xFF. Sets 1 and 3 get 0xFF only. Any other set gets no exit write.
- R11: Only one read is outstanding at a time. After a read strobe, no further read or write strobe is issued until read-valid has been seen. Read and write strobes are never high together.
- R12: A start pulse that arrives while a probe is running is ignored.
- R13: An accepted start clears all result outputs, so unused region entries read 0. Done is a one-cycle pulse, and exactly one of found and missing is set while it is high.
- R14: After reset, done, found, missing and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| bus_addr_o | output | ADDR_W | Byte address to the flash |
| bus_wdata_o | output | 8 | Write data |
| bus_wr_o | output | 1 | Write strobe, one cycle per write |
| bus_rd_o | output | 1 | Read strobe, one cycle per read |
| bus_rdata_i | input | 8 | Read data, valid with bus_rvalid_i |
| bus_rvalid_i | input | 1 | Read data valid |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| found_o | output | 1 | Signature matched |
| missing_o | output | 1 | Signature mismatch |
| cmdset_o | output | 16 | Command-set code |
| wexp_o | output | 9 | Write timeout exponent (microseconds) |
| eexp_o | output | 9 | Erase timeout exponent (milliseconds) |
| size_exp_o | output | 8 | log2 of device size in bytes |
| nreg_o | output | NR_W | Number of regions after the limit |
| blk_cnt_o | output | 17*MAX_REG | Block count per region, region r at bits 17r upward |
| blk_size_o | output | 24*MAX_REG | Block size in bytes per region, region r at bits 24r upward |
| reg_base_o | output | OFS_W*MAX_REG | Start offset per region, region r at bits OFS_W*r upward |

## Verification
The assertions assume that the bus returns exactly one read-valid pulse for each read strobe, and only after that strobe. They also assume that start is a single-cycle pulse. The bench's flash responder keeps to this contract. It answers each read after a delay of one to three cycles, never raises read-valid unprompted, and tracks query mode from the command writes it sees, so a wrong entry sequence shows up as bad data. Start is pulsed for one cycle only. The one deliberate overlap is a second start pulse issued during a probe, which is the ignored-start case.

// File: rtl/cfi_probe.sv
module cfi_probe #(
  parameter int ADDR_W  = 8,
  parameter int MAX_REG = 8,
  parameter int OFS_W   = 32,
  localparam int NR_W   = $clog2(MAX_REG + 1),
  localparam int RI_W   = $clog2(MAX_REG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  output logic [ADDR_W-1:0]        bus_addr_o,
  output logic [7:0]               bus_wdata_o,
  output logic                     bus_wr_o,
  output logic                     bus_rd_o,
  input  logic [7:0]               bus_rdata_i,
  input  logic                     bus_rvalid_i,
  output logic                     done_o,
  output logic                     found_o,
  output logic                     missing_o,
  output logic [15:0]              cmdset_o,
  output logic [8:0]               wexp_o,
  output logic [8:0]               eexp_o,
  output logic [7:0]               size_exp_o,
  output logic [NR_W-1:0]          nreg_o,
  output logic [17*MAX_REG-1:0]    blk_cnt_o,
  output logic [24*MAX_REG-1:0]    blk_size_o,
  output logic [OFS_W*MAX_REG-1:0] reg_base_o
);

  typedef enum logic [2:0] {
    P_IDLE, P_RESET, P_QUERY, P_HDR, P_REG, P_EXIT0, P_EXIT1, P_DONE
  } phase_t;

  phase_t            ph;
  logic              pend;
  logic [3:0]        k;
  logic [RI_W+1:0]   j;
  logic [7:0]        lo;
  logic [OFS_W-1:0]  acc;
  logic [6:0]        cmd_off;
  logic [15:0]       code;
  logic [23:0]       bsz_new;
  logic [OFS_W-1:0]  prod;
  logic [RI_W-1:0]   r;
  phase_t            exit_ph;

  logic [16:0]       cnt_q  [MAX_REG];
  logic [23:0]       bsz_q  [MAX_REG];
  logic [OFS_W-1:0]  base_q [MAX_REG];

  function automatic logic [6:0] hdr_off(input logic [3:0] idx);
    case (idx)
      4'd0:    return 7'h10;
      4'd1:    return 7'h11;
      4'd2:    return 7'h12;
      4'd3:    return 7'h13;
      4'd4:    return 7'h14;
      4'd5:    return 7'h1F;
      4'd6:    return 7'h23;
      4'd7:    return 7'h21;
      4'd8:    return 7'h25;
      4'd9:    return 7'h27;
      default: return 7'h2C;
    endcase
  endfunction

  always_comb begin
    case (ph)
      P_QUERY: cmd_off = 7'h55;
      P_HDR:   cmd_off = hdr_off(k);
      P_REG:   cmd_off = 7'h2D + 7'(j);
      default: cmd_off = 7'h00;
    endcase
  end

  assign bus_addr_o  = ADDR_W'({cmd_off, 1'b0});
  assign bus_wdata_o = (ph == P_QUERY) ? 8'h98 : (ph == P_EXIT1) ? 8'hFF : 8'hF0;
  assign bus_wr_o    = (ph == P_RESET) || (ph == P_QUERY) || (ph == P_EXIT0) || (ph == P_EXIT1);
  assign bus_rd_o    = ((ph == P_HDR) || (ph == P_REG)) && !pend;

  assign r       = j[RI_W+1:2];
  assign code    = {bus_rdata_i, lo};
  assign bsz_new = (code == 16'd0) ? 24'd128 : {code, 8'h00};
  assign prod    = OFS_W'(bsz_new) * OFS_W'(cnt_q[r]);
  assign exit_ph = (cmdset_o == 16'd2) ? P_EXIT0 :
                   ((cmdset_o == 16'd1) || (cmdset_o == 16'd3)) ? P_EXIT1 : P_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph         <= P_IDLE;
      pend       <= 1'b0;
      k          <= '0;
      j          <= '0;
      lo         <= '0;
      acc        <= '0;
      done_o     <= 1'b0;
      found_o    <= 1'b0;
      missing_o  <= 1'b0;
      cmdset_o   <= '0;
      wexp_o     <= '0;
      eexp_o     <= '0;
      size_exp_o <= '0;
      nreg_o     <= '0;
      for (int i = 0; i < MAX_REG; i++) begin
        cnt_q[i]  <= '0;
        bsz_q[i]  <= '0;
        base_q[i] <= '0;
      end
    end else begin
      case (ph)
        P_IDLE: begin
          done_o <= 1'b0;
          if (start_i) begin
            ph         <= P_RESET;
            found_o    <= 1'b0;
            missing_o  <= 1'b0;
            cmdset_o   <= '0;
            wexp_o     <= '0;
            eexp_o     <= '0;
            size_exp_o <= '0;
            nreg_o     <= '0;
            acc        <= '0;
            for (int i = 0; i < MAX_REG; i++) begin
              cnt_q[i]  <= '0;
              bsz_q[i]  <= '0;
              base_q[i] <= '0;
            end
          end
        end
        P_RESET: ph <= P_QUERY;
        P_QUERY: begin
          ph   <= P_HDR;
          k    <= '0;
          pend <= 1'b0;
        end
        P_HDR: begin
          if (!pend) pend <= 1'b1;
          else if (bus_rvalid_i) begin
            pend <= 1'b0;
            k    <= k + 4'd1;
            case (k)
              4'd0: if (bus_rdata_i != 8'h51) begin missing_o <= 1'b1; ph <= P_DONE; end
              4'd1: if (bus_rdata_i != 8'h52) begin missing_o <= 1'b1; ph <= P_DONE; end
              4'd2: if (bus_rdata_i != 8'h59) begin missing_o <= 1'b1; ph <= P_DONE; end
              4'd3: cmdset_o[7:0]  <= bus_rdata_i;
              4'd4: cmdset_o[15:8] <= bus_rdata_i;
              4'd5: wexp_o <= {1'b0, bus_rdata_i};
              4'd6: wexp_o <= wexp_o + {1'b0, bus_rdata_i};
              4'd7: eexp_o <= {1'b0, bus_rdata_i};
              4'd8: eexp_o <= eexp_o + {1'b0, bus_rdata_i};
              4'd9: size_exp_o <= bus_rdata_i;
              default: begin
                nreg_o <= (32'(bus_rdata_i) > MAX_REG) ? NR_W'(MAX_REG) : NR_W'(bus_rdata_i);
                j      <= '0;
                if (bus_rdata_i == 8'd0) begin
                  found_o <= 1'b1;
                  ph      <= exit_ph;
                end else ph <= P_REG;
              end
            endcase
          end
        end
        P_REG: begin
          if (!pend) pend <= 1'b1;
          else if (bus_rvalid_i) begin
            pend <= 1'b0;
            j    <= j + 1'b1;
            case (j[1:0])
              2'd0, 2'd2: lo <= bus_rdata_i;
              2'd1: cnt_q[r] <= 17'(code) + 17'd1;
              default: begin
                bsz_q[r]  <= bsz_new;
                base_q[r] <= acc;
                acc       <= acc + prod;
                if (NR_W'(r) + NR_W'(1) == nreg_o) begin
                  found_o <= 1'b1;
                  ph      <= exit_ph;
                end
              end
            endcase
          end
        end
        P_EXIT0: ph <= P_EXIT1;
        P_EXIT1: ph <= P_DONE;
        default: begin
          done_o <= 1'b1;
          ph     <= P_IDLE;
        end
      endcase
    end
  end

  for (genvar g = 0; g < MAX_REG; g++) begin : g_flat
    assign blk_cnt_o[17*g +: 17]        = cnt_q[g];
    assign blk_size_o[24*g +: 24]       = bsz_q[g];
    assign reg_base_o[OFS_W*g +: OFS_W] = base_q[g];
  end

  // R11
  rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd_o |=> !bus_rd_o && !bus_wr_o);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));
  // R13
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (found_o != missing_o));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6
  nreg_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(nreg_o) <= MAX_REG);
  // R10
  exit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_o && bus_wdata_o == 8'hFF) |-> (cmdset_o == 16'd1 || cmdset_o == 16'd2 || cmdset_o == 16'd3));

endmodule

// File: tb/cfi_probe_tb.sv
module cfi_probe_tb_top;
  localparam int CLK_P = 10;
  localparam int MR = 8;

  typedef struct packed {
    logic [1:0]  bad;
    logic [15:0] cs;
    logic [7:0]  w0, w1, e0, e1, sz, nr;
    logic [15:0] c0, s0;
    logic        zs;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'd0, 16'h0002, 8'd4,   8'd5,   8'd9,   8'd4,   8'h17, 8'd2,  16'h0007, 16'h0020, 1'b0},
    '{2'd0, 16'h0003, 8'd8,   8'd3,   8'd10,  8'd2,   8'h18, 8'd4,  16'h0100, 16'h0001, 1'b1},
    '{2'd0, 16'h0001, 8'd255, 8'd255, 8'd255, 8'd255, 8'h1A, 8'd12, 16'h0000, 16'h0200, 1'b1},
    '{2'd0, 16'h0107, 8'd1,   8'd1,   8'd1,   8'd1,   8'h10, 8'd0,  16'h0000, 16'h0000, 1'b0},
    '{2'd2, 16'h0002, 8'd1,   8'd1,   8'd1,   8'd1,   8'h10, 8'd3,  16'h0001, 16'h0001, 1'b0},
    '{2'd3, 16'h0001, 8'd1,   8'd1,   8'd1,   8'd1,   8'h10, 8'd3,  16'h0001, 16'h0001, 1'b0},
    '{2'd0, 16'h0001, 8'd0,   8'd0,   8'd0,   8'd0,   8'h20, 8'd1,  16'hFFFF, 16'hFFFF, 1'b0}
  };

  logic clk = 0, rst_n = 0, start_i = 0;
  logic [7:0] bus_addr_o, bus_wdata_o, bus_rdata_i = 0, size_exp_o;
  logic bus_wr_o, bus_rd_o, bus_rvalid_i = 0, done_o, found_o, missing_o;
  logic [15:0] cmdset_o;
  logic [8:0] wexp_o, eexp_o;
  logic [3:0] nreg_o;
  logic [17*MR-1:0] blk_cnt_o;
  logic [24*MR-1:0] blk_size_o;
  logic [32*MR-1:0] reg_base_o;

  cfi_probe dut_i (.*);

  always #(CLK_P/2) clk = ~clk;

  logic [7:0] qmem [128];
  int nrd = 0, nwr = 0, odd = 0, total = 0, fails = 0;
  logic [6:0] wr_off [16];
  logic [7:0] wr_dat [16];
  bit qmode = 0, pending = 0, finished = 0;
  int wait_n = 0;
  logic [7:0] rval;

  // flash responder: one read at a time, 1..3 cycle delay
  initial forever begin
    @(negedge clk);
    bus_rvalid_i = 0;
    if (pending) begin
      if (wait_n == 0) begin bus_rvalid_i = 1; bus_rdata_i = rval; pending = 0; end
      else wait_n--;
    end
    if (bus_rd_o) begin
      if (bus_addr_o[0]) odd++;
      rval = qmode ? qmem[bus_addr_o[7:1]] : 8'hFF;
      pending = 1; wait_n = nrd % 3; nrd++;
    end
    if (bus_wr_o) begin
      if (bus_addr_o[0]) odd++;
      if (nwr < 16) begin wr_off[nwr] = bus_addr_o[7:1]; wr_dat[nwr] = bus_wdata_o; end
      nwr++;
      if (bus_addr_o[7:1] == 7'h55 && bus_wdata_o == 8'h98) qmode = 1;
      else if (bus_wdata_o == 8'hF0 || bus_wdata_o == 8'hFF) qmode = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic run_vec(input vec_t v, input bit extra);
    int nr, exp_rd, exp_wr, guard, p;
    logic [31:0] acc;
    logic [16:0] ecnt;
    logic [15:0] cm1, ecode;
    logic [23:0] ebsz;
    logic [7:0] sig [3];
    sig[0] = 8'h51; sig[1] = 8'h52; sig[2] = 8'h59;
    for (int i = 0; i < 128; i++) qmem[i] = 8'hA5;
    for (int i = 0; i < 3; i++) qmem[7'h10 + i] = sig[i];
    if (v.bad != 0) qmem[7'h10 + 7'(v.bad) - 1] = sig[v.bad - 1] ^ 8'h20;
    qmem[7'h13] = v.cs[7:0]; qmem[7'h14] = v.cs[15:8];
    qmem[7'h1F] = v.w0; qmem[7'h23] = v.w1; qmem[7'h21] = v.e0; qmem[7'h25] = v.e1;
    qmem[7'h27] = v.sz; qmem[7'h2C] = v.nr;
    for (int r = 0; r < MR; r++) begin
      cm1 = v.c0 + 16'(r);
      ecode = (v.zs && r == 1) ? 16'h0 : v.s0 + 16'(r);
      qmem[7'h2D + 7'(4*r)] = cm1[7:0]; qmem[7'h2E + 7'(4*r)] = cm1[15:8];
      qmem[7'h2F + 7'(4*r)] = ecode[7:0]; qmem[7'h30 + 7'(4*r)] = ecode[15:8];
    end
    nrd = 0; nwr = 0; odd = 0;
    @(negedge clk); start_i = 1; @(negedge clk); start_i = 0;
    if (extra) begin repeat (8) @(negedge clk); start_i = 1; @(negedge clk); start_i = 0; end
    guard = 0;
    while (!done_o && guard < 5000) begin @(negedge clk); guard++; end
    chk(done_o, "R13", "done seen", done_o, 1);
    nr = (v.nr > MR) ? MR : v.nr;
    p = v.bad;
    chk(found_o == (p == 0), "R3", "found", found_o, p == 0);
    chk(missing_o == (p != 0), "R3", "missing", missing_o, p != 0);
    exp_rd = (p != 0) ? p : 11 + 4*nr;
    chk(nrd == exp_rd, "R6", "read count", nrd, exp_rd);
    chk(odd == 0, "R1", "odd addresses", odd, 0);
    chk(wr_off[0] == 7'h00 && wr_dat[0] == 8'hF0, "R2", "first write", {wr_off[0], wr_dat[0]}, 16'h00F0);
    chk(wr_off[1] == 7'h55 && wr_dat[1] == 8'h98, "R2", "second write", {wr_off[1], wr_dat[1]}, 16'h5598);
    exp_wr = 2;
    if (p == 0) begin
      if (v.cs == 2) begin
        exp_wr = 4;
        chk(wr_off[2] == 0 && wr_dat[2] == 8'hF0, "R10", "exit F0", wr_dat[2], 8'hF0);
        chk(wr_off[3] == 0 && wr_dat[3] == 8'hFF, "R10", "exit FF", wr_dat[3], 8'hFF);
      end else if (v.cs == 1 || v.cs == 3) begin
        exp_wr = 3;
        chk(wr_off[2] == 0 && wr_dat[2] == 8'hFF, "R10", "exit FF only", wr_dat[2], 8'hFF);
      end
    end
    chk(nwr == exp_wr, "R10", "write count", nwr, exp_wr);
    chk(cmdset_o == ((p == 0) ? v.cs : 16'h0), "R4", "cmdset", cmdset_o, (p == 0) ? v.cs : 16'h0);
    if (p == 0) begin
      chk(wexp_o == 9'(v.w0) + 9'(v.w1), "R5", "write exp", wexp_o, 9'(v.w0) + 9'(v.w1));
      chk(eexp_o == 9'(v.e0) + 9'(v.e1), "R5", "erase exp", eexp_o, 9'(v.e0) + 9'(v.e1));
      chk(size_exp_o == v.sz, "R5", "size exp", size_exp_o, v.sz);
      chk(nreg_o == 4'(nr), "R6", "region count", nreg_o, nr);
    end else
      chk(nreg_o == 0, "R13", "region count cleared", nreg_o, 0);
    acc = 0;
    for (int r = 0; r < MR; r++) begin
      if (p == 0 && r < nr) begin
        ecnt = 17'(v.c0 + 16'(r)) + 17'd1;
        ecode = (v.zs && r == 1) ? 16'h0 : v.s0 + 16'(r);
        ebsz = (ecode == 0) ? 24'd128 : {ecode, 8'h00};
        chk(blk_cnt_o[17*r +: 17] == ecnt, "R7", "block count", blk_cnt_o[17*r +: 17], ecnt);
        chk(blk_size_o[24*r +: 24] == ebsz, "R8", "block size", blk_size_o[24*r +: 24], ebsz);
        chk(reg_base_o[32*r +: 32] == acc, "R9", "region start", reg_base_o[32*r +: 32], acc);
        acc = acc + 32'(ebsz) * 32'(ecnt);
      end else begin
        chk(blk_cnt_o[17*r +: 17] == 0 && blk_size_o[24*r +: 24] == 0 && reg_base_o[32*r +: 32] == 0,
            "R13", "unused region zero", blk_cnt_o[17*r +: 17], 0);
      end
    end
    @(negedge clk);
    chk(!done_o, "R13", "done one cycle", done_o, 0);
    if (extra) begin
      repeat (60) @(negedge clk);
      chk(nwr == exp_wr && !done_o, "R12", "no second probe", nwr, exp_wr);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!done_o && !found_o && !missing_o, "R14", "flags after reset", {done_o, found_o, missing_o}, 0);
    chk(!bus_rd_o && !bus_wr_o, "R14", "strobes after reset", {bus_rd_o, bus_wr_o}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 7; i++) run_vec(VECS[i], 1'b0);
    run_vec(VECS[0], 1'b1);
    run_vec(VECS[4], 1'b0);
    run_vec(VECS[1], 1'b0);
    finish_run();
  end
endmodule